// File: doc/BRIEF.md
# Serial Control Register Port

This block is the control-plane front end of a voice codec. A host microcontroller reaches it over four wires: an active-low enable, a shift clock, a data input and a data output. Every access is one frame. The frame carries a direction flag first, then a 3-bit register address, then 8 data bits, most significant bit first. A frame can be 12 bits long, or 16 bits long with 4 trailing padding bits that are ignored. A write lands in the addressed register once its last data bit has arrived. On a read, the addressed byte is shifted out during the data phase. At every other time the output driver is switched off.

The block holds eight 8-bit registers and decodes the fields that the codec datapath uses onto plain output pins: coding mode, channel resets, mutes, pad, channel enables, gains, side-tone level and high-pass filter controls. The external power-down pin is active low and works as an asynchronous reset. It returns every register to its initial value. The effective power-down output is the OR of that pin and a software bit.

The serial pins are sampled by the system clock through two-stage synchronisers, so the shift clock must stay well below a quarter of the system clock. The port has no streaming payload and therefore no valid/ready handshake: every pin is a plain control or status signal.

Top module: `ctl_serial_port`

## Requirements
- R1: While `pdn_n` is low and after it rises, register 0 and register 1 read 0x00, register 2 reads 0x33, register 3 reads 0x00, and registers 4 to 7 read 0x00. The decoded outputs follow these values.
- R2: A 12-bit frame with flag 0 (write) writes bits B7..B0 into the register whose address is A2..A1..A0. The bit order is flag, A2, A1, A0, B7 .. B0.
- R3: A 16-bit frame acts like a 12-bit frame. Its last 4 bits are ignored, whatever their value.
- R4: In a frame with flag 1 (read), `sdo_oe` is high from the low phase that follows the A0 rising edge until the falling edge after the B0 rising edge. During that window `sdo` presents B7 first, and each later bit follows a shift-clock falling edge. Outside that window `sdo_oe` is low.
- R5: If `sel_n` rises before the B0 rising edge, the frame is discarded and no register changes.
- R6: `pwr_down` is high when `pdn_n` is low or register 0 bit 5 is 1. While it is high, `sdo_oe` stays low, but write frames are still accepted.
- R7: Register 1 decodes as follows: `mode` = bits 7:6, `tx_rst` = bit 5, `rx_rst` = bit 4, `tx_mute` = bit 3, `rx_mute` = bit 2, `rx_pad` = bit 0.
- R8: Register 2 decodes as follows: `tx_off` = bit 7, `tx_gain` = bits 6:4, `rx_off` = bit 3, `rx_gain` = bits 2:0.
- R9: Register 3 decodes as follows: `st_gain` = bits 7:5, `st_on` = 1 exactly when `st_gain` is not 000, `hpf_sel` = bit 1, `hpf_bypass` = bit 0.
- R10: Pulling `pdn_n` low after registers have been written restores every register to the values of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pdn_n | input | 1 | Active-low power-down pin, also the asynchronous register reset |
| sel_n | input | 1 | Active-low frame enable |
| sclk | input | 1 | Serial shift clock; input is sampled on its rising edge |
| sdi | input | 1 | Serial data in: flag, address, data |
| sdo | output | 1 | Serial read data; 0 when not driven |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |
| pwr_down | output | 1 | Effective power-down (pin OR software bit) |
| mode | output | 2 | Coding mode field |
| tx_rst | output | 1 | Transmit coder reset |
| rx_rst | output | 1 | Receive decoder reset |
| tx_mute | output | 1 | Transmit mute |
| rx_mute | output | 1 | Receive mute |
| rx_pad | output | 1 | Receive 12 dB pad insert |
| tx_off | output | 1 | Transmit channel off |
| tx_gain | output | 3 | Transmit gain code |
| rx_off | output | 1 | Receive channel off |
| rx_gain | output | 3 | Receive gain code |
| st_gain | output | 3 | Side-tone gain code |
| st_on | output | 1 | Side-tone path enabled |
| hpf_sel | output | 1 | High-pass cut-off select |
| hpf_bypass | output | 1 | High-pass filter disable |

## Verification
A table of write-then-read pairs drives the main function. The pairs cover decoded registers, undecoded registers and both frame lengths, and they use patterns with alternating and asymmetric bits. A shifted, reversed or misaddressed byte therefore shows up both in the readback and in the decoded pins. The 16-bit frames drive ones into the padding, which separates a port that ignores the padding from one that keeps shifting it in. Directed frames then cover an aborted write, reads during software power-down (the output enable must stay low), and a second pin reset after the registers have been written, which separates a true reset from a reset that only happens once.

// File: rtl/ctl_serial_pkg.sv
package ctl_serial_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam int REG_SYS  = 0;
  localparam int REG_CODE = 1;
  localparam int REG_PATH = 2;
  localparam int REG_TONE = 3;

  localparam int SYS_PD_BIT = 5;

  function automatic logic [DATA_W-1:0] reg_init(input int idx);
    return (idx == REG_PATH) ? DATA_W'(8'h33) : '0;
  endfunction
endpackage

// File: rtl/ctl_sp_sync.sv
module ctl_sp_sync #(
  parameter int          W   = 3,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST[i];
        s2 <= RST[i];
      end else begin
        s1 <= d_in[i];
        s2 <= s1;
      end
    end
    assign d_out[i] = s2;
  end
endmodule

// File: rtl/ctl_sp_frame.sv
module ctl_sp_frame #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n_s,
  input  logic          sclk_s,
  input  logic          sdi_s,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_active,
  output logic          rd_bit
);
  localparam int BITS = 1 + AW + DW;
  localparam int SW   = BITS - 1;
  localparam int CW   = $clog2(BITS + 1);

  logic          sclk_q;
  logic          rise, fall;
  logic [CW-1:0] cnt;
  logic [SW-1:0] sh;
  logic [DW-1:0] rd_sh;
  logic          rd_start;

  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;

  assign rd_addr  = {sh[AW-2:0], sdi_s};
  assign rd_start = rise & ~sel_n_s & (cnt == CW'(AW)) & sh[AW-1];

  assign wr_en   = rise & ~sel_n_s & (cnt == CW'(BITS - 1)) & ~sh[SW-1];
  assign wr_addr = sh[SW-2 -: AW];
  assign wr_data = {sh[DW-2:0], sdi_s};
  assign rd_bit  = rd_sh[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sh        <= '0;
      rd_sh     <= '0;
      rd_active <= 1'b0;
    end else if (sel_n_s) begin
      cnt       <= '0;
      rd_active <= 1'b0;
    end else begin
      if (rise && cnt != CW'(BITS)) begin
        cnt <= cnt + 1'b1;
        sh  <= {sh[SW-2:0], sdi_s};
      end
      if (rd_start) begin
        rd_active <= 1'b1;
        rd_sh     <= rd_data;
      end
      if (fall && rd_active && cnt > CW'(AW + 1) && cnt < CW'(BITS))
        rd_sh <= {rd_sh[DW-2:0], 1'b0};
      if (fall && cnt == CW'(BITS))
        rd_active <= 1'b0;
    end
  end

  // R4: dropping the enable ends the read window on the next cycle
  p_oe_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_s |=> !rd_active);

  // R4: the presented bit only moves on a shift-clock falling edge
  p_sdo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && !fall) |=> $stable(rd_bit));

  // R2: a commit coincides with the final counted bit
  p_commit_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt == CW'(BITS)));
endmodule

// File: rtl/ctl_sp_regfile.sv
module ctl_sp_regfile
  import ctl_serial_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          sw_pd,
  output logic [1:0]    mode,
  output logic          tx_rst,
  output logic          rx_rst,
  output logic          tx_mute,
  output logic          rx_mute,
  output logic          rx_pad,
  output logic          tx_off,
  output logic [2:0]    tx_gain,
  output logic          rx_off,
  output logic [2:0]    rx_gain,
  output logic [2:0]    st_gain,
  output logic          st_on,
  output logic          hpf_sel,
  output logic          hpf_bypass
);
  localparam int NREG = 1 << AW;

  logic [NREG-1:0][DW-1:0] regs;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs[i] <= reg_init(i);
      else if (wr_en && wr_addr == AW'(i))        regs[i] <= wr_data;
    end
  end

  assign rd_data = regs[rd_addr];

  assign sw_pd      = regs[REG_SYS][SYS_PD_BIT];
  assign mode       = regs[REG_CODE][7:6];
  assign tx_rst     = regs[REG_CODE][5];
  assign rx_rst     = regs[REG_CODE][4];
  assign tx_mute    = regs[REG_CODE][3];
  assign rx_mute    = regs[REG_CODE][2];
  assign rx_pad     = regs[REG_CODE][0];
  assign tx_off     = regs[REG_PATH][7];
  assign tx_gain    = regs[REG_PATH][6:4];
  assign rx_off     = regs[REG_PATH][3];
  assign rx_gain    = regs[REG_PATH][2:0];
  assign st_gain    = regs[REG_TONE][7:5];
  assign st_on      = |regs[REG_TONE][7:5];
  assign hpf_sel    = regs[REG_TONE][1];
  assign hpf_bypass = regs[REG_TONE][0];

  // R5: without a commit strobe the register file holds its contents
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs));
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import ctl_serial_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic       clk,
  input  logic       pdn_n,
  input  logic       sel_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe,
  output logic       pwr_down,
  output logic [1:0] mode,
  output logic       tx_rst,
  output logic       rx_rst,
  output logic       tx_mute,
  output logic       rx_mute,
  output logic       rx_pad,
  output logic       tx_off,
  output logic [2:0] tx_gain,
  output logic       rx_off,
  output logic [2:0] rx_gain,
  output logic [2:0] st_gain,
  output logic       st_on,
  output logic       hpf_sel,
  output logic       hpf_bypass
);
  logic [2:0]    pins_s;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en, rd_active, rd_bit, sw_pd;

  ctl_sp_sync #(.W(3), .RST(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (pdn_n),
    .d_in  ({sel_n, sclk, sdi}),
    .d_out (pins_s)
  );

  ctl_sp_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk       (clk),
    .rst_n     (pdn_n),
    .sel_n_s   (pins_s[2]),
    .sclk_s    (pins_s[1]),
    .sdi_s     (pins_s[0]),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_active (rd_active),
    .rd_bit    (rd_bit)
  );

  ctl_sp_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (pdn_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .sw_pd      (sw_pd),
    .mode       (mode),
    .tx_rst     (tx_rst),
    .rx_rst     (rx_rst),
    .tx_mute    (tx_mute),
    .rx_mute    (rx_mute),
    .rx_pad     (rx_pad),
    .tx_off     (tx_off),
    .tx_gain    (tx_gain),
    .rx_off     (rx_off),
    .rx_gain    (rx_gain),
    .st_gain    (st_gain),
    .st_on      (st_on),
    .hpf_sel    (hpf_sel),
    .hpf_bypass (hpf_bypass)
  );

  assign pwr_down = ~pdn_n | sw_pd;
  assign sdo_oe   = rd_active & ~pwr_down;
  assign sdo      = sdo_oe & rd_bit;
endmodule

// File: tb/ctl_serial_port_bench.sv
`timescale 1ns/1ps
module ctl_serial_port_bench;
  logic clk = 1'b0;
  logic pdn_n = 1'b0, sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, pwr_down;
  logic [1:0] mode;
  logic tx_rst, rx_rst, tx_mute, rx_mute, rx_pad, tx_off, rx_off;
  logic [2:0] tx_gain, rx_gain, st_gain;
  logic st_on, hpf_sel, hpf_bypass;

  int errors = 0, checks = 0;
  logic done = 1'b0;
  logic [7:0] m [8];

  always #10 clk = ~clk;

  ctl_serial_port u_ctl_serial_port (
    .clk(clk), .pdn_n(pdn_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .pwr_down(pwr_down), .mode(mode),
    .tx_rst(tx_rst), .rx_rst(rx_rst), .tx_mute(tx_mute), .rx_mute(rx_mute),
    .rx_pad(rx_pad), .tx_off(tx_off), .tx_gain(tx_gain), .rx_off(rx_off),
    .rx_gain(rx_gain), .st_gain(st_gain), .st_on(st_on), .hpf_sel(hpf_sel),
    .hpf_bypass(hpf_bypass)
  );

  // {long frame, address, data}
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 3'd1, 8'hED}, {1'b1, 3'd2, 8'hA5}, {1'b0, 3'd3, 8'hE3},
    {1'b1, 3'd3, 8'h21}, {1'b0, 3'd5, 8'h5A}, {1'b1, 3'd7, 8'hC3},
    {1'b1, 3'd1, 8'h12}, {1'b0, 3'd2, 8'h4C}};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m[i] = 8'h00;
    m[2] = 8'h33;
  endtask

  task automatic chk_dec(input string tag);
    logic [21:0] act, exp;
    act = {mode, tx_rst, rx_rst, tx_mute, rx_mute, rx_pad, tx_off, tx_gain,
           rx_off, rx_gain, st_gain, st_on, hpf_sel, hpf_bypass, pwr_down};
    exp = {m[1][7:6], m[1][5], m[1][4], m[1][3], m[1][2], m[1][0], m[2][7],
           m[2][6:4], m[2][3], m[2][2:0], m[3][7:5], |m[3][7:5], m[3][1],
           m[3][0], (~pdn_n | m[0][5])};
    chk(tag, 32'(act), 32'(exp));
  endtask

  task automatic do_frame(input logic rw, input logic [2:0] a, input logic [7:0] d,
                          input int nbits, input logic pd, output logic [7:0] got,
                          output int oe_bad);
    logic [11:0] word;
    word = {rw, a, d};
    got = 8'h00;
    oe_bad = 0;
    sel_n = 1'b0;
    tick(6);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 12) ? word[11-i] : 1'b1;
      tick(5);
      if (i >= 4 && i < 12) got[11-i] = sdo;
      if (sdo_oe !== (rw && i >= 4 && i < 12 && !pd)) oe_bad++;
      tick(1);
      sclk = 1'b1;
      tick(6);
      sclk = 1'b0;
    end
    tick(5);
    if (sdo_oe !== 1'b0) oe_bad++;
    sel_n = 1'b1;
    tick(8);
    if (sdo_oe !== 1'b0) oe_bad++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    int bad;
    model_reset();
    tick(4);
    // R1/R6: during the pin reset
    chk("R6 pwr_down with pin low", 32'(pwr_down), 32'd1);
    chk("R1 sdo_oe low in reset", 32'(sdo_oe), 32'd0);
    chk_dec("R1 decode while pin low");
    pdn_n = 1'b1;
    tick(4);
    chk_dec("R1 decode after release");
    do_frame(1'b1, 3'd2, 8'h00, 12, 1'b0, got, bad);
    chk("R1 reg2 initial", 32'(got), 32'h33);
    chk("R4 oe window reg2 read", 32'(bad), 32'd0);
    do_frame(1'b1, 3'd0, 8'h00, 12, 1'b0, got, bad);
    chk("R1 reg0 initial", 32'(got), 32'h00);

    // table of write/read pairs: R2 (12-bit), R3 (16-bit), R7 R8 R9 decode
    for (int v = 0; v < 8; v++) begin
      logic lng;
      logic [2:0] a;
      logic [7:0] d;
      {lng, a, d} = VEC[v];
      do_frame(1'b0, a, d, lng ? 16 : 12, 1'b0, got, bad);
      m[a] = d;
      chk(lng ? "R3 write frame oe quiet" : "R2 write frame oe quiet", 32'(bad), 32'd0);
      do_frame(1'b1, a, 8'h00, lng ? 16 : 12, 1'b0, got, bad);
      chk(lng ? "R3 readback" : "R2 readback", 32'(got), 32'(d));
      chk("R4 read oe window", 32'(bad), 32'd0);
      chk_dec("R7 R8 R9 decoded fields");
    end

    // R5: aborted write to reg 2 after 7 bits
    do_frame(1'b0, 3'd2, 8'hFF, 7, 1'b0, got, bad);
    chk_dec("R5 decode after abort");
    do_frame(1'b1, 3'd2, 8'h00, 12, 1'b0, got, bad);
    chk("R5 reg2 unchanged", 32'(got), 32'(m[2]));
    // R5: abort one bit short of B0
    do_frame(1'b0, 3'd3, 8'h00, 11, 1'b0, got, bad);
    do_frame(1'b1, 3'd3, 8'h00, 16, 1'b0, got, bad);
    chk("R5 reg3 unchanged at 11 bits", 32'(got), 32'(m[3]));

    // R6: software power-down
    do_frame(1'b0, 3'd0, 8'h20, 12, 1'b0, got, bad);
    m[0] = 8'h20;
    chk("R6 pwr_down from bit", 32'(pwr_down), 32'd1);
    do_frame(1'b1, 3'd0, 8'h00, 12, 1'b1, got, bad);
    chk("R6 oe held low in power-down", 32'(bad), 32'd0);
    do_frame(1'b0, 3'd0, 8'h00, 12, 1'b1, got, bad);
    m[0] = 8'h00;
    chk("R6 write accepted in power-down", 32'(pwr_down), 32'd0);
    do_frame(1'b1, 3'd0, 8'h00, 12, 1'b0, got, bad);
    chk("R6 reg0 cleared", 32'(got), 32'h00);

    // R10: second pin reset after writes
    do_frame(1'b0, 3'd6, 8'h99, 12, 1'b0, got, bad);
    pdn_n = 1'b0;
    tick(3);
    chk("R10 pwr_down during pin reset", 32'(pwr_down), 32'd1);
    pdn_n = 1'b1;
    model_reset();
    tick(3);
    chk_dec("R10 decode restored");
    do_frame(1'b1, 3'd2, 8'h00, 12, 1'b0, got, bad);
    chk("R10 reg2 restored", 32'(got), 32'h33);
    do_frame(1'b1, 3'd6, 8'h00, 16, 1'b0, got, bad);
    chk("R10 reg6 restored", 32'(got), 32'h00);
    do_frame(1'b1, 3'd1, 8'h00, 12, 1'b0, got, bad);
    chk("R10 reg1 restored", 32'(got), 32'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule